// File: doc/BRIEF.md
# Windowed Keyed-Restart Watchdog

This block is a supervisory timer for a processor subsystem. A slow-clock enable, one pulse per slow-clock period (nominally 32768 Hz), feeds a prescaler that divides by `PRESC` (128 by default, giving 256 counter ticks per second). Each prescaler tick moves a down-counter one step toward underflow. Software keeps the system alive by writing a restart command, protected by a key byte, to the control register. A restart that comes too early, while the counter is still above a programmable window value, counts as a fault, and so does an underflow. Each fault sets a sticky status flag. It can raise a level interrupt, pulse a reset request, or both.

A timeout of s seconds is programmed as a reload value of 256·s − 1. A mode write restarts the counter, just as a keyed restart does. Any restart makes the block ignore register writes for three slow-clock periods, so software must space its writes about four slow periods apart. While the disable bit is set, the timing fields are frozen. Two halt options stop counting while the processor is idle or under debug.

Top module: `wdt_keyed`

## Requirements
- R1: After reset the mode register reads reload = 2^CW−1, window = 2^CW−1, reset enable = 1, and all other option bits 0. The counter equals the reload value, the status is 0, and irq and rst_req are low.
- R2: While the block runs, the counter drops by one on every PRESC-th slow tick. With reload R, the underflow flag is set on slow tick PRESC·(R+1) after a restart, and the counter reloads to R at that tick.
- R3: A control write (reg_sel = 0) that has 0xA5 in bits 31:24 and bit 0 set reloads the counter and restarts the prescaler. A control write with any other key changes neither the counter nor the prescaler and raises no fault.
- R4: For three slow ticks after any restart, control and mode writes are ignored. A write on the fourth slow tick takes effect.
- R5: A mode write (reg_sel = 1) also restarts the counter. Its layout is: reload in bits CW−1:0, window in bits 2CW−1:CW, then from bit 2CW upward: irq enable, reset enable, disable, idle halt, debug halt.
- R6: While the disable bit is set, and in the write that sets it, the reload and window fields keep their old values. While disabled, the counter holds and no fault occurs.
- R7: A keyed restart while the counter is above the window value sets status bit 1 (window error), as long as window < reload. A restart with the counter at or below the window value is legal.
- R8: On each fault, rst_req pulses high for one cycle if reset enable is set. irq stays high while a status flag is set and irq enable is set.
- R9: With idle halt set, cpu_idle = 1 freezes the counter and the prescaler. With debug halt set, dbg_halt = 1 does the same.
- R10: Status bit 0 is underflow and bit 1 is window error. Both flags stay set until a stat_rd pulse clears them. A fault in the same cycle as the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slck_tick | input | 1 | One-cycle pulse per slow-clock period |
| cpu_idle | input | 1 | Processor idle indication |
| dbg_halt | input | 1 | Debugger halt indication |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = control register, 1 = mode register |
| reg_wdata | input | 32 | Write data |
| stat_rd | input | 1 | Status read strobe; clears the flags |
| mode_rdata | output | 32 | Current mode register |
| count | output | CW | Current counter value |
| status | output | 2 | {window error, underflow} |
| irq | output | 1 | Fault interrupt (level) |
| rst_req | output | 1 | Reset request pulse |

## Verification
The bench runs with slck_tick high every clock and PRESC = 4. A write sampled at edge E0 shows up in mode_rdata, count, status and rst_req right after E0. Counter steps then fall on edges E0+4k, and an underflow with reload R is due exactly after edge E0+4(R+1). The lockout ends so that a write sampled at E0+4 is accepted, while writes at E0+1 through E0+3 are not. The bench drives and samples on the falling edge and counts falling edges from each write. It checks one cycle before each due edge that the result has not yet appeared, and checks right after the due edge that it has.

// File: rtl/wdt_keyed.sv
module wdt_keyed #(
  parameter int          CW    = 12,
  parameter int          PRESC = 128,
  parameter int          LOCK  = 3,
  parameter logic [7:0]  KEY   = 8'hA5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slck_tick,
  input  logic          cpu_idle,
  input  logic          dbg_halt,
  input  logic          reg_wr,
  input  logic          reg_sel,
  input  logic [31:0]   reg_wdata,
  input  logic          stat_rd,
  output logic [31:0]   mode_rdata,
  output logic [CW-1:0] count,
  output logic [1:0]    status,
  output logic          irq,
  output logic          rst_req
);
  localparam int PW  = (PRESC > 1) ? $clog2(PRESC) : 1;
  localparam int LW  = $clog2(LOCK + 1);
  localparam int OPT = 2 * CW;

  logic [CW-1:0] reload_q, window_q, cnt_q;
  logic          irq_en_q, rst_en_q, dis_q, idle_h_q, dbg_h_q;
  logic [PW-1:0] presc_q;
  logic [LW-1:0] lock_q;
  logic          uf_q, werr_q, rst_req_q;

  wire locked   = (lock_q != '0);
  wire ctl_wr   = reg_wr & ~reg_sel & ~locked;
  wire restart  = ctl_wr & (reg_wdata[31:24] == KEY) & reg_wdata[0];
  wire mode_wr  = reg_wr & reg_sel & ~locked;
  wire new_dis  = reg_wdata[OPT+2];
  wire take_tim = mode_wr & ~dis_q & ~new_dis;
  wire reload_ev = restart | mode_wr;
  wire [CW-1:0] next_reload = take_tim ? reg_wdata[CW-1:0] : reload_q;

  wire run  = ~dis_q & ~(idle_h_q & cpu_idle) & ~(dbg_h_q & dbg_halt);
  wire step = run & slck_tick;
  wire tick = step & (presc_q == PW'(PRESC - 1));

  wire win_fault = restart & ~dis_q & (window_q < reload_q) & (cnt_q > window_q);
  wire uf_fault  = tick & (cnt_q == '0) & ~reload_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '1;
      window_q <= '1;
      irq_en_q <= 1'b0;
      rst_en_q <= 1'b1;
      dis_q    <= 1'b0;
      idle_h_q <= 1'b0;
      dbg_h_q  <= 1'b0;
    end else if (mode_wr) begin
      if (take_tim) begin
        reload_q <= reg_wdata[CW-1:0];
        window_q <= reg_wdata[2*CW-1:CW];
      end
      irq_en_q <= reg_wdata[OPT];
      rst_en_q <= reg_wdata[OPT+1];
      dis_q    <= new_dis;
      idle_h_q <= reg_wdata[OPT+3];
      dbg_h_q  <= reg_wdata[OPT+4];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '1;
      presc_q <= '0;
      lock_q  <= '0;
    end else begin
      if (reload_ev)  cnt_q <= next_reload;
      else if (tick)  cnt_q <= (cnt_q == '0) ? reload_q : cnt_q - 1'b1;

      if (reload_ev)  presc_q <= '0;
      else if (step)  presc_q <= tick ? '0 : presc_q + 1'b1;

      if (reload_ev)                 lock_q <= LW'(LOCK);
      else if (locked && slck_tick)  lock_q <= lock_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uf_q      <= 1'b0;
      werr_q    <= 1'b0;
      rst_req_q <= 1'b0;
    end else begin
      if (uf_fault)     uf_q <= 1'b1;
      else if (stat_rd) uf_q <= 1'b0;
      if (win_fault)    werr_q <= 1'b1;
      else if (stat_rd) werr_q <= 1'b0;
      rst_req_q <= rst_en_q & (uf_fault | win_fault);
    end
  end

  assign mode_rdata = {{(32-OPT-5){1'b0}}, dbg_h_q, idle_h_q, dis_q, rst_en_q, irq_en_q,
                       window_q, reload_q};
  assign count   = cnt_q;
  assign status  = {werr_q, uf_q};
  assign irq     = irq_en_q & (uf_q | werr_q);
  assign rst_req = rst_req_q;
endmodule

// File: rtl/wdt_keyed_chk.sv
module wdt_keyed_chk #(
  parameter int CW = 12,
  parameter int LW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic          reg_sel,
  input logic          stat_rd,
  input logic [31:0]   mode_rdata,
  input logic [CW-1:0] count,
  input logic [1:0]    status,
  input logic          rst_req,
  input logic [LW-1:0] lock_q
);
  localparam int OPT = 2 * CW;

  assert_mode_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel && lock_q != '0) |=> $stable(mode_rdata));

  assert_timing_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mode_rdata[OPT+2] |=> $stable(mode_rdata[2*CW-1:0]));

  assert_disabled_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_rdata[OPT+2] && !reg_wr) |=> $stable(count));

  assert_rst_needs_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (status != 2'b00));

  assert_uf_requests_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[0]) |-> (rst_req == $past(mode_rdata[OPT+1])));

  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (status[0] && !stat_rd) |=> status[0]);

  assert_count_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= mode_rdata[CW-1:0]);
endmodule

bind wdt_keyed wdt_keyed_chk #(.CW(CW), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .stat_rd(stat_rd),
  .mode_rdata(mode_rdata), .count(count), .status(status), .rst_req(rst_req),
  .lock_q(lock_q)
);

// File: tb/wdt_keyed_tb_top.sv
module wdt_keyed_tb_top;
  localparam int CW = 12;
  localparam int P  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slck_tick = 1'b1, cpu_idle = 1'b0, dbg_halt = 1'b0;
  logic reg_wr = 1'b0, reg_sel = 1'b0, stat_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] mode_rdata;
  logic [CW-1:0] count;
  logic [1:0] status;
  logic irq, rst_req;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  wdt_keyed #(.CW(CW), .PRESC(P)) dut_i (
    .clk(clk), .rst_n(rst_n), .slck_tick(slck_tick), .cpu_idle(cpu_idle),
    .dbg_halt(dbg_halt), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .stat_rd(stat_rd), .mode_rdata(mode_rdata), .count(count), .status(status),
    .irq(irq), .rst_req(rst_req)
  );

  function automatic logic [31:0] mk(int rl, int wn, bit ie, bit re, bit ds, bit ih, bit dh);
    return {3'b0, dh, ih, ds, re, ie, wn[CW-1:0], rl[CW-1:0]};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(bit sel, logic [31:0] d);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_stat();
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
  endtask

  int rsts = 0;
  always @(negedge clk) if (rst_n && rst_req) rsts++;

  initial begin
    int r0;
    step(3);
    rst_n = 1'b1;
    step(1);
    chk("R1 mode", mode_rdata, mk(4095, 4095, 0, 1, 0, 0, 0));
    chk("R1 count", count, 4095);
    chk("R1 status", status, 0);
    chk("R1 irq/rst", {irq, rst_req}, 0);

    // R2 / R5 / R8 underflow sweep over small reload values
    for (int r = 0; r < 7; r++) begin
      step(4);
      wr(1, mk(r, 4095, 0, 1, 0, 0, 0));
      chk("R5 reload on mode write", count, r);
      rd_stat();
      step(4 * r + 2);
      chk("R2 no early underflow", status, 0);
      step(1);
      chk("R2 underflow flag", status, 1);
      chk("R2 reload after underflow", count, r);
      chk("R8 reset pulse", rst_req, 1);
      step(1);
      chk("R8 pulse width", rst_req, 0);
    end

    // R3 wrong key, then keyed restart; R4 lockout
    step(4);
    wr(1, mk(20, 4095, 0, 1, 0, 0, 0));
    rd_stat();
    step(7);
    chk("R2 count after 8 edges", count, 18);
    wr(0, 32'h5A00_0001);
    chk("R3 wrong key no reload", count, 18);
    step(3);
    chk("R3 wrong key prescaler kept", count, 17);
    chk("R3 wrong key no fault", status, 0);
    wr(0, 32'hA500_0001);
    chk("R3 keyed restart", count, 20);
    wr(1, mk(7, 4095, 0, 1, 0, 0, 0));
    chk("R4 locked mode write", mode_rdata, mk(20, 4095, 0, 1, 0, 0, 0));
    step(2);
    wr(1, mk(7, 4095, 0, 1, 0, 0, 0));
    chk("R4 write on fourth tick", mode_rdata, mk(7, 4095, 0, 1, 0, 0, 0));
    chk("R4 write restarts", count, 7);

    // R7 window
    step(4);
    wr(1, mk(12, 3, 0, 1, 0, 0, 0));
    step(4);
    r0 = rsts;
    wr(0, 32'hA500_0001);
    chk("R7 early restart flagged", status, 2);
    chk("R8 reset on window fault", rst_req, 1);
    chk("R7 count reloaded", count, 12);
    rd_stat();
    chk("R10 cleared by read", status, 0);
    step(35);
    chk("R7 count at window", count, 3);
    wr(0, 32'hA500_0001);
    chk("R7 restart at window legal", status, 0);
    chk("R8 one reset pulse", rsts - r0, 1);

    // R6 disable freezes timing fields
    step(4);
    wr(1, mk(9, 2, 0, 1, 1, 0, 0));
    chk("R6 timing kept on disabling write", mode_rdata, mk(12, 3, 0, 1, 1, 0, 0));
    step(40);
    chk("R6 counter holds", count, 12);
    chk("R6 no fault", status, 0);
    wr(1, mk(9, 2, 0, 1, 0, 0, 0));
    chk("R6 timing kept while disabled", mode_rdata, mk(12, 3, 0, 1, 0, 0, 0));
    step(4);
    wr(1, mk(9, 8, 1, 0, 0, 0, 0));
    chk("R6 timing taken when enabled", mode_rdata, mk(9, 8, 1, 0, 0, 0, 0));

    // R8 interrupt, R10 sticky
    r0 = rsts;
    step(39);
    chk("R8 irq low before fault", irq, 0);
    step(1);
    chk("R8 irq on underflow", {irq, status}, 3'b101);
    step(5);
    chk("R10 flag sticky", {irq, status}, 3'b101);
    rd_stat();
    chk("R10 read clears irq", {irq, status}, 0);
    chk("R8 no reset when disabled", rsts - r0, 0);

    // R9 halts
    step(4);
    wr(1, mk(9, 8, 0, 1, 0, 1, 1));
    cpu_idle = 1'b1;
    step(50);
    chk("R9 idle halt", count, 9);
    cpu_idle = 1'b0; dbg_halt = 1'b1;
    step(50);
    chk("R9 debug halt", count, 9);
    dbg_halt = 1'b0;
    step(3);
    chk("R9 prescaler held", count, 9);
    step(1);
    chk("R9 resumes", count, 8);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule